// File: doc/BRIEF.md
# Parallel Frame-Port Transmit Controller

This block moves words from a local show-ahead buffer onto a parallel frame-data port. The port is clocked by the STROBE clock. On each rising edge the block either presents one buffered word with an active-low valid strobe, or it leaves the strobe inactive. Every buffered word carries a frame-end tag. The word that carries the tag goes out with an active-low sync marker, so frames of any length are delimited by their last word.

The receiver has two asynchronous flow-control lines, both active low. One is a hold-off: when it is asserted the block must stop quickly and then respect a guard time before it resumes. The other is a not-ready line: while it is asserted no word may be sent. Both lines pass through a two-stage synchronizer before the controller uses them. After every reset the block waits a fixed number of STROBE periods before it sends anything.

The controller has five states:
- `ST_WARM` counts the startup periods and leaves for `ST_GUARD` once the count is complete, or for `ST_HALT` if a hold-off is present.
- `ST_IDLE` and `ST_SEND` launch a word whenever the buffer has data and neither flow-control line is asserted. `ST_SEND` means a word was launched in the previous cycle. A hold-off takes either state to `ST_HALT`.
- `ST_HALT` stays put while the hold-off is asserted and moves to `ST_GUARD` when it clears.
- `ST_GUARD` waits `GUARD_CYCLES` periods and then enters `ST_IDLE`. It returns to `ST_HALT` if the hold-off comes back.

Top module: `fpx_tx_ctrl`

## Requirements
- R1: After a reset is released, `port_valid_n` stays high for at least `STARTUP_CYCLES` (default 16) rising edges of `strobe_clk`.
- R2: `buf_rd` is high only when `buf_empty` is low. The edge at which `buf_rd` is high drives `port_valid_n` low, and every other edge drives it high. With an empty buffer the port therefore shows no valid word.
- R3: Words appear on `port_data` unchanged and in buffer order, one word per cycle in which `port_valid_n` is low.
- R4: `port_sync_n` is low exactly on words whose `buf_eof` bit was 1, where 1 marks the last word of a frame. It is never low while `port_valid_n` is high.
- R5: While `rx_hold_n` is held low, `port_valid_n` goes high within 16 edges and stays high.
- R6: After `rx_hold_n` returns high, `port_valid_n` stays high for at least `GUARD_CYCLES` + 2 edges. This covers two synchronizer edges plus the guard time, which defaults to 1 and may be set to 2.
- R7: While `rx_busy_n` is held low, no word is read or sent once the synchronizer latency has passed. After it returns high the pending words go out and none is lost.
- R8: A synchronous reset (`rst` high) holds `port_valid_n` and `port_sync_n` high and `buf_rd` low, and restarts the startup count of R1.
- R9: Frames of any length are supported, single-word frames included. Each frame produces exactly one sync marker, on its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_clk | input | 1 | STROBE clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| buf_empty | input | 1 | Buffer holds no word |
| buf_data | input | DATA_W | Word at the head of the buffer (show-ahead) |
| buf_eof | input | 1 | Frame-end tag of the head word (1 = last word of its frame) |
| buf_rd | output | 1 | Pops the head word at this rising edge |
| rx_hold_n | input | 1 | Asynchronous receiver hold-off, active low |
| rx_busy_n | input | 1 | Asynchronous receiver not-ready, active low |
| port_data | output | DATA_W | Port data word, registered |
| port_valid_n | output | 1 | Port data valid, active low, registered |
| port_sync_n | output | 1 | Port sync marker, active low, registered |

## Verification
Two things can land in the same cycle. A hold-off or not-ready edge can reach the controller in the very cycle that the frame-end word is at the head of the buffer. The bench provokes this by dropping `rx_hold_n` once that tagged word is the only one left, and by dropping both flow-control lines together. Whether or not the tagged word escapes before the stop, the scoreboard requires that the word, when it does appear, carries the sync marker, and that no sync is ever seen without a valid word. The bench also measures the stop latency and the resume gap in edges and compares them against the limits in R5 and R6.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;

    typedef enum logic [2:0] {
        ST_WARM  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SEND  = 3'd2,
        ST_HALT  = 3'd3,
        ST_GUARD = 3'd4
    } tx_state_e;

endpackage

// File: rtl/fpx_sync2.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous receiver control lines.
module fpx_sync2 #(
    parameter int               WIDTH  = 2,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= INIT;
            end
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/fpx_warmup.sv
`timescale 1ns/1ps
// Counts STROBE periods after reset; done stays high once reached.
module fpx_warmup #(
    parameter int COUNT = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done
);

    localparam int         CW   = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LAST);

    AST_WARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R1

endmodule

// File: rtl/fpx_tx_fsm.sv
`timescale 1ns/1ps
// Transmit sequencer: state register, guard timer and registered port.
module fpx_tx_fsm
    import fpx_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int GUARD_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_done,
    input  logic              hold_s,
    input  logic              busy_s,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_eof,
    output logic              buf_rd,
    output logic [DATA_W-1:0] port_data,
    output logic              port_valid_n,
    output logic              port_sync_n
);

    localparam int            GW    = $clog2(GUARD_CYCLES + 1);
    localparam logic [GW-1:0] GLAST = GW'(GUARD_CYCLES - 1);

    tx_state_e     state_q, state_d;
    logic [GW-1:0] gcnt_q;
    logic          may_send;
    logic          fire;

    assign may_send = (state_q == ST_IDLE) || (state_q == ST_SEND);
    assign fire     = may_send && !hold_s && !busy_s && !buf_empty && !rst;
    assign buf_rd   = fire;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM: begin
                if (warm_done) begin
                    state_d = hold_s ? ST_HALT : ST_GUARD;
                end
            end
            ST_IDLE, ST_SEND: begin
                if (hold_s) begin
                    state_d = ST_HALT;
                end else if (fire) begin
                    state_d = ST_SEND;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!hold_s) begin
                    state_d = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (hold_s) begin
                    state_d = ST_HALT;
                end else if (gcnt_q == GLAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_WARM;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WARM;
        end else begin
            state_q <= state_d;
        end
    end

    // guard timer: counts periods spent in ST_GUARD
    always_ff @(posedge clk) begin
        if (rst || state_q != ST_GUARD) begin
            gcnt_q <= '0;
        end else begin
            gcnt_q <= gcnt_q + GW'(1);
        end
    end

    // registered port outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            port_data    <= '0;
            port_valid_n <= 1'b1;
            port_sync_n  <= 1'b1;
        end else if (fire) begin
            port_data    <= buf_data;
            port_valid_n <= 1'b0;
            port_sync_n  <= !buf_eof;
        end else begin
            port_valid_n <= 1'b1;
            port_sync_n  <= 1'b1;
        end
    end

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        hold_s |=> port_valid_n); // R5

    AST_GUARD_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_s) |=> port_valid_n ##1 port_valid_n); // R6

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy_s |=> port_valid_n); // R7

    AST_READ_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> !buf_empty); // R2

endmodule

// File: rtl/fpx_tx_ctrl.sv
`timescale 1ns/1ps
// Top: parallel frame-port transmit controller.
module fpx_tx_ctrl #(
    parameter int DATA_W         = 16,
    parameter int STARTUP_CYCLES = 16,
    parameter int GUARD_CYCLES   = 1,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              strobe_clk,
    input  logic              rst,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_eof,
    output logic              buf_rd,
    input  logic              rx_hold_n,
    input  logic              rx_busy_n,
    output logic [DATA_W-1:0] port_data,
    output logic              port_valid_n,
    output logic              port_sync_n
);

    localparam int            UW    = $clog2(STARTUP_CYCLES + 1);
    localparam logic [UW-1:0] ULAST = UW'(STARTUP_CYCLES);

    logic [1:0] ctl_sync;
    logic       hold_s;
    logic       busy_s;
    logic       warm_done;

    fpx_sync2 #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .INIT   (2'b11)
    ) u_sync (
        .clk  (strobe_clk),
        .rst  (rst),
        .din  ({rx_busy_n, rx_hold_n}),
        .dout (ctl_sync)
    );

    assign hold_s = !ctl_sync[0];
    assign busy_s = !ctl_sync[1];

    fpx_warmup #(
        .COUNT (STARTUP_CYCLES)
    ) u_warm (
        .clk  (strobe_clk),
        .rst  (rst),
        .done (warm_done)
    );

    fpx_tx_fsm #(
        .DATA_W       (DATA_W),
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_fsm (
        .clk          (strobe_clk),
        .rst          (rst),
        .warm_done    (warm_done),
        .hold_s       (hold_s),
        .busy_s       (busy_s),
        .buf_empty    (buf_empty),
        .buf_data     (buf_data),
        .buf_eof      (buf_eof),
        .buf_rd       (buf_rd),
        .port_data    (port_data),
        .port_valid_n (port_valid_n),
        .port_sync_n  (port_sync_n)
    );

    // independent count of periods since reset, for the startup check
    logic [UW-1:0] since_rst_q;
    always_ff @(posedge strobe_clk) begin
        if (rst) begin
            since_rst_q <= '0;
        end else if (since_rst_q != ULAST) begin
            since_rst_q <= since_rst_q + UW'(1);
        end
    end

    AST_STARTUP_HOLD: assert property (@(posedge strobe_clk) disable iff (rst)
        !port_valid_n |-> since_rst_q == ULAST); // R1

    AST_READ_LOADS: assert property (@(posedge strobe_clk) disable iff (rst)
        buf_rd |=> !port_valid_n); // R2

    AST_NO_READ_NO_VALID: assert property (@(posedge strobe_clk) disable iff (rst)
        !buf_rd |=> port_valid_n); // R2

    AST_SYNC_IN_WORD: assert property (@(posedge strobe_clk) disable iff (rst)
        !port_sync_n |-> !port_valid_n); // R4

endmodule

// File: tb/sim_fpx_tx_ctrl.sv
`timescale 1ns/1ps
module sim_fpx_tx_ctrl;

    localparam int DW      = 16;
    localparam int STARTUP = 16;
    localparam int GUARD   = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          buf_empty;
    logic [DW-1:0] buf_data;
    logic          buf_eof;
    logic          buf_rd;
    logic          rx_hold_n = 1'b1;
    logic          rx_busy_n = 1'b1;
    logic [DW-1:0] port_data;
    logic          port_valid_n;
    logic          port_sync_n;

    always #2.5 clk = ~clk;

    fpx_tx_ctrl #(
        .DATA_W         (DW),
        .STARTUP_CYCLES (STARTUP),
        .GUARD_CYCLES   (GUARD)
    ) u0 (
        .strobe_clk   (clk),
        .rst          (rst),
        .buf_empty    (buf_empty),
        .buf_data     (buf_data),
        .buf_eof      (buf_eof),
        .buf_rd       (buf_rd),
        .rx_hold_n    (rx_hold_n),
        .rx_busy_n    (rx_busy_n),
        .port_data    (port_data),
        .port_valid_n (port_valid_n),
        .port_sync_n  (port_sync_n)
    );

    // bench-side show-ahead buffer model
    logic [DW:0]  mem [0:511];
    logic [8:0]   wr_ptr = '0;
    logic [8:0]   rd_ptr = '0;
    logic         rd_seen = 1'b0;
    logic [DW:0]  exp_q [$];

    assign buf_empty = (rd_ptr == wr_ptr);
    assign {buf_eof, buf_data} = mem[rd_ptr];

    always @(posedge clk) begin
        if (buf_rd) rd_ptr <= rd_ptr + 9'd1;
        rd_seen <= buf_rd;
    end

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_sync   = 0;
    int  cyc      = 0;
    bit  mon_on   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_frame(input int len, input logic [DW-1:0] base);
        for (int i = 0; i < len; i++) begin
            logic [DW:0] w;
            w = {(i == len - 1), base + DW'(i)};
            mem[wr_ptr] = w;
            wr_ptr = wr_ptr + 9'd1;
            exp_q.push_back(w);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 1000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "words left unsent", exp_q.size(), 0);
        chk(port_valid_n == 1'b1, "R2", "valid with empty buffer", port_valid_n, 1);
    endtask

    // edges from now until the first valid word
    task automatic edges_to_valid(output int k);
        k = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (!port_valid_n) begin
                k = i;
                break;
            end
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk(port_valid_n == !rd_seen, "R2", "valid vs read strobe",
                port_valid_n, !rd_seen);
            if (!port_valid_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected word", port_data, 0);
                end else begin
                    logic [DW:0] e;
                    e = exp_q.pop_front();
                    chk(port_data == e[DW-1:0], "R3", "word data", port_data, e[DW-1:0]);
                    chk(port_sync_n == !e[DW], "R4", "sync on frame end",
                        port_sync_n, !e[DW]);
                end
                if (!port_sync_n) n_sync++;
            end else begin
                chk(port_sync_n == 1'b1, "R4", "sync without valid", port_sync_n, 1);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int s0;
        bit quiet;

        // R8: reset state with data waiting
        push_frame(3, 16'h1000);
        push_frame(1, 16'h2000);
        push_frame(5, 16'h3000);
        repeat (3) @(negedge clk);
        chk(port_valid_n == 1'b1, "R8", "valid in reset", port_valid_n, 1);
        chk(port_sync_n == 1'b1, "R8", "sync in reset", port_sync_n, 1);
        chk(buf_rd == 1'b0, "R8", "read in reset", buf_rd, 0);

        // R1: startup hold-off
        rst = 1'b0;
        mon_on = 1'b1;
        edges_to_valid(k);
        chk(k > STARTUP && k <= STARTUP + 6, "R1", "edges before first valid", k, STARTUP + 1);
        drain("R3");

        // R9: variable-length frames including single words
        s0 = n_sync;
        push_frame(1, 16'h4000);
        push_frame(2, 16'h4100);
        push_frame(7, 16'h4200);
        push_frame(1, 16'h4300);
        drain("R9");
        chk(n_sync - s0 == 4, "R9", "sync pulses for 4 frames", n_sync - s0, 4);

        // R5/R6: hold-off mid-frame
        push_frame(40, 16'h5000);
        repeat (5) @(negedge clk);
        rx_hold_n = 1'b0;
        k = 99;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (port_valid_n) begin
                k = i;
                break;
            end
        end
        chk(k <= 16, "R5", "edges to stop", k, 16);
        quiet = 1'b1;
        s0 = exp_q.size();
        repeat (30) begin
            @(negedge clk);
            if (!port_valid_n) quiet = 1'b0;
        end
        chk(quiet, "R5", "valid during hold-off", !quiet, 0);
        chk(exp_q.size() == s0, "R5", "words sent during hold-off", exp_q.size(), s0);
        rx_hold_n = 1'b1;
        edges_to_valid(k);
        chk(k >= GUARD + 2 && k <= GUARD + 6, "R6", "resume gap in edges", k, GUARD + 2);
        drain("R6");

        // R7: not-ready blocks everything
        rx_busy_n = 1'b0;
        repeat (4) @(negedge clk);
        push_frame(6, 16'h6000);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!port_valid_n || rd_seen) quiet = 1'b0;
        end
        chk(quiet, "R7", "activity while not ready", !quiet, 0);
        chk(exp_q.size() == 6, "R7", "words held back", exp_q.size(), 6);
        rx_busy_n = 1'b1;
        drain("R7");

        // collision: hold-off arrives as the frame-end word is at the head
        s0 = n_sync;
        push_frame(4, 16'h7000);
        for (int i = 0; i < 200 && exp_q.size() > 1; i++) @(negedge clk);
        rx_hold_n = 1'b0;
        repeat (10) @(negedge clk);
        rx_hold_n = 1'b1;
        drain("R4");
        chk(n_sync - s0 == 1, "R4", "sync kept across hold-off", n_sync - s0, 1);

        // both lines together; hold-off released first
        push_frame(3, 16'h7100);
        rx_hold_n = 1'b0;
        rx_busy_n = 1'b0;
        repeat (6) @(negedge clk);
        rx_hold_n = 1'b1;
        quiet = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (!port_valid_n) quiet = 1'b0;
        end
        chk(quiet, "R7", "valid with not-ready still low", !quiet, 0);
        rx_busy_n = 1'b1;
        drain("R7");

        // R8: reset mid-run restarts startup count
        rst = 1'b1;
        repeat (2) @(negedge clk);
        push_frame(2, 16'h8000);
        @(negedge clk);
        chk(port_valid_n == 1'b1 && port_sync_n == 1'b1, "R8", "outputs in reset",
            {port_valid_n, port_sync_n}, 2'b11);
        chk(buf_rd == 1'b0, "R8", "read in reset", buf_rd, 0);
        rst = 1'b0;
        edges_to_valid(k);
        chk(k > STARTUP && k <= STARTUP + 6, "R8", "startup restarted", k, STARTUP + 1);
        drain("R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule